// File: doc/BRIEF.md
# Four-Step Cyclic Code Counter

This block is a 3-bit counter that walks through a fixed loop of four code words instead of the binary sequence. On each rising clock edge where the count enable is high, the code moves one step around the loop 000 → 011 → 001 → 111 → 000. A single-cycle flag, `loop_done`, marks each return to 000 from 111. Downstream logic can use the code as a non-monotonic step pattern and the flag as a once-per-loop event.

The reset input is active low. Asserting it clears the block at once, without waiting for a clock edge. Releasing it takes effect only after two rising edges of the local clock, so the first step never races the reset release. The four 3-bit values outside the loop cannot arise in normal operation. If one ever appears in the state register, the next enabled edge sends it to 000, so the counter cannot lock up.

Top module: `seq_cycle_counter`

## Requirements
- R1: While `rst_n` is low, `code` is 000 and `loop_done` is 0, with no clock edge needed. After `rst_n` rises, the first two rising edges change nothing, and the third enabled edge is the first step.
- R2: On an enabled rising edge with `code` equal to 000, `code` becomes 011.
- R3: On an enabled rising edge with `code` equal to 011, `code` becomes 001.
- R4: On an enabled rising edge with `code` equal to 001, `code` becomes 111.
- R5: On an enabled rising edge with `code` equal to 111, `code` becomes 000.
- R6: A rising edge with `en` low leaves `code` unchanged and drives `loop_done` to 0.
- R7: From any of the codes 010, 100, 101 or 110, the next-state logic selects 000. The next enabled edge therefore puts the counter back in the loop.
- R8: `loop_done` is 1 for exactly the one cycle after an enabled edge that moved `code` from 111 to 000. It is 0 in every other cycle.
- R9: With `en` held high, `code` repeats with a period of four cycles, and `loop_done` rises once in each period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset: asserts at once, releases in step with the clock |
| en | input | 1 | Count enable; low holds the code |
| code | output | 3 | Current code word of the loop |
| loop_done | output | 1 | One-cycle flag after the step from 111 to 000 |

## Verification
The hold function and the loop-completion flag can meet on one edge. To provoke this, the bench drops `en` for the edge right after the wrap. The code must then stay at 000 while `loop_done` falls back to 0, which shows that the flag records the wrap step and is not a decode of the current code.

Reset and the wrap step can also coincide. The bench asserts `rst_n` while the code sits at 111 with `en` high, and it requires 000 and a low flag before the next clock edge.

Recovery from the four codes outside the loop is judged at the ports of the next-state unit. The bench sweeps all eight codes through that unit.

// File: rtl/seq_cycle_pkg.sv
package seq_cycle_pkg;
  localparam int CODE_W = 3;
  typedef logic [CODE_W-1:0] code_t;

  // loop order; the order of these four values is the behaviour
  localparam code_t STEP_A = 3'b000;
  localparam code_t STEP_B = 3'b011;
  localparam code_t STEP_C = 3'b001;
  localparam code_t STEP_D = 3'b111;
endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/seq_next_logic.sv
module seq_next_logic
  import seq_cycle_pkg::*;
(
  input  code_t cur,
  output code_t nxt,
  output logic  at_last
);
  always_comb begin
    unique case (cur)
      STEP_A:  nxt = STEP_B;
      STEP_B:  nxt = STEP_C;
      STEP_C:  nxt = STEP_D;
      STEP_D:  nxt = STEP_A;
      default: nxt = STEP_A; // codes off the loop re-enter at the start
    endcase
  end

  assign at_last = (cur == STEP_D);
endmodule

// File: rtl/seq_cycle_counter.sv
module seq_cycle_counter
  import seq_cycle_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  output logic [CODE_W-1:0] code,
  output logic              loop_done
);
  logic  rst_sync_n;
  code_t code_q;
  code_t code_d;
  logic  at_last;
  logic  done_q;
  logic  done_d;

  seq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  seq_next_logic u_next (
    .cur     (code_q),
    .nxt     (code_d),
    .at_last (at_last)
  );

  always_comb begin
    done_d = en & at_last;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      code_q <= STEP_A;
    end else if (en) begin
      code_q <= code_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) done_q <= 1'b0;
    else             done_q <= done_d;
  end

  assign code      = code_q;
  assign loop_done = done_q;
endmodule

// File: rtl/seq_cycle_counter_chk.sv
module seq_cycle_counter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run_n,
  input logic       en,
  input logic [2:0] code,
  input logic       loop_done
);
  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RST_CLEAR: assert (code == 3'b000 && !loop_done); // R1
    end
  end

  AST_STEP_FROM_000: assert property (@(posedge clk) disable iff (!run_n)
    (en && code == 3'b000) |=> (code == 3'b011)); // R2
  AST_STEP_FROM_011: assert property (@(posedge clk) disable iff (!run_n)
    (en && code == 3'b011) |=> (code == 3'b001)); // R3
  AST_STEP_FROM_001: assert property (@(posedge clk) disable iff (!run_n)
    (en && code == 3'b001) |=> (code == 3'b111)); // R4
  AST_STEP_FROM_111: assert property (@(posedge clk) disable iff (!run_n)
    (en && code == 3'b111) |=> (code == 3'b000)); // R5
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!run_n)
    !en |=> ($stable(code) && !loop_done)); // R6
  AST_OFF_LOOP_RECOVER: assert property (@(posedge clk) disable iff (!run_n)
    (en && code != 3'b000 && code != 3'b011 && code != 3'b001 && code != 3'b111)
    |=> (code == 3'b000)); // R7
  AST_DONE_AFTER_WRAP: assert property (@(posedge clk) disable iff (!run_n)
    (en && code == 3'b111) |=> loop_done); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!run_n)
    loop_done |=> !loop_done); // R8
  AST_DONE_AT_START: assert property (@(posedge clk) disable iff (!run_n)
    loop_done |-> (code == 3'b000)); // R8
endmodule

bind seq_cycle_counter seq_cycle_counter_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_n     (rst_sync_n),
  .en        (en),
  .code      (code),
  .loop_done (loop_done)
);

// File: tb/seq_cycle_counter_tb.sv
`timescale 1ns/1ps
module seq_cycle_counter_tb;
  logic       clk;
  logic       rst_n;
  logic       en;
  logic [2:0] code;
  logic       loop_done;
  logic [2:0] sw_cur;
  logic [2:0] sw_nxt;
  logic       sw_last;

  int checks;
  int fails;
  logic [2:0] exp_code;
  logic       exp_done;

  seq_cycle_counter u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .code      (code),
    .loop_done (loop_done)
  );

  seq_next_logic u_nxt (
    .cur     (sw_cur),
    .nxt     (sw_nxt),
    .at_last (sw_last)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [2:0] model_next(input logic [2:0] c);
    case (c)
      3'b000:  return 3'b011;
      3'b011:  return 3'b001;
      3'b001:  return 3'b111;
      3'b111:  return 3'b000;
      default: return 3'b000;
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock; model updates on the edge, compare at the falling edge
  task automatic step(input string req);
    @(posedge clk);
    exp_done = en && (exp_code == 3'b111);
    if (en) exp_code = model_next(exp_code);
    @(negedge clk);
    check(req, {1'b0, code}, {1'b0, exp_code});
    check(req, {3'b0, loop_done}, {3'b0, exp_done});
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int ones;
    checks = 0; fails = 0;
    rst_n = 1'b0; en = 1'b0; sw_cur = 3'b000;
    exp_code = 3'b000; exp_done = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset code", {1'b0, code}, 4'h0);
    check("R1 reset flag", {3'b0, loop_done}, 4'h0);

    // release with enable already high: two edges of no change
    rst_n = 1'b1; en = 1'b1;
    @(negedge clk); check("R1 release edge 1", {1'b0, code}, 4'h0);
    @(negedge clk); check("R1 release edge 2", {1'b0, code}, 4'h0);

    // first loop, one edge per requirement
    step("R2"); check("R2 code", {1'b0, code}, 4'h3);
    step("R3"); check("R3 code", {1'b0, code}, 4'h1);
    step("R4"); check("R4 code", {1'b0, code}, 4'h7);
    step("R5"); check("R5 code", {1'b0, code}, 4'h0);
    check("R8 flag after wrap", {3'b0, loop_done}, 4'h1);

    // hold on the edge right after the wrap: flag must drop, code stays
    en = 1'b0;
    step("R6 hold after wrap");
    check("R8 flag single", {3'b0, loop_done}, 4'h0);

    // free run: period four, one flag per period
    en = 1'b1;
    ones = 0;
    for (int i = 0; i < 16; i++) begin
      step("R9 free run");
      if (loop_done) ones++;
    end
    check("R9 flags per 16", ones[3:0], 4'h4);

    // enable patterns from a small arithmetic generator
    for (int i = 0; i < 120; i++) begin
      en = ((i * 7 + i / 3) % 5) < 3;
      step("R6 R8 pattern");
    end

    // reset landing on the wrap edge
    en = 1'b1;
    while (code != 3'b111) step("R9 seek");
    #1 rst_n = 1'b0;
    #0.5;
    check("R1 async clear", {1'b0, code}, 4'h0);
    check("R1 async flag", {3'b0, loop_done}, 4'h0);
    @(negedge clk);
    rst_n = 1'b1; en = 1'b0;
    exp_code = 3'b000;
    repeat (2) @(negedge clk);
    en = 1'b1;
    step("R2 after rerelease");

    // exhaustive sweep of the next-state unit, including off-loop codes
    for (int c = 0; c < 8; c++) begin
      sw_cur = c[2:0];
      #1;
      check("R7 next", {1'b0, sw_nxt}, {1'b0, model_next(c[2:0])});
      check("R8 last", {3'b0, sw_last}, {3'b0, c[2:0] == 3'b111});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule